// File: doc/BRIEF.md
# 8-bit ALU with Borrow Flags

This block is the arithmetic and logic unit of a small accumulator-style 8-bit core. It takes the working-register value W and a second operand F, which is either a file-register value or an 8-bit immediate chosen upstream. It also takes the current status flags and an operation code. From these it produces an 8-bit result, the updated Carry, Digit Carry and Zero flags, and a write mask that shows which of those flags the operation changed. Subtraction returns F minus W. In that case Carry and Digit Carry mean "no borrow" and "no borrow out of the low nibble", so one adder serves both directions.

An operation enters on a valid/ready handshake and its result leaves on a second one. A transfer happens on any rising clock edge where valid and ready are both high. Once the producer raises `in_valid` it must hold it and all operand fields steady until `in_ready` accepts them.

The `REG_OUT` parameter sets the latency. With `REG_OUT`=1 (the default), results pass through one register stage. While `out_valid` is high and `out_ready` is low, that stage holds its contents, and `in_ready` drops until the consumer takes the result. With `REG_OUT`=0 the unit is purely combinational: `out_valid` follows `in_valid` and `in_ready` follows `out_ready`.

Operand storage, register-file addressing and instruction decode are outside the block.

Top module: `alu8_core`

## Requirements
- R1: Operation code 1 (add) returns (F+W) mod 256. C is the carry out of bit 7, DC is the carry out of bit 3, and Z is set when the result is zero. All three flags are written.
- R2: Operation code 2 (subtract) returns (F−W) mod 256. C is 1 exactly when F ≥ W unsigned, DC is 1 exactly when F[3:0] ≥ W[3:0], and Z marks a zero result. All three flags are written.
- R3: Operation codes 0 (pass F), 3 (F AND W), 4 (F OR W), 5 (F XOR W) and 6 (complement F) write only Z, which is set when the result is zero.
- R4: Operation code 7 (F+1) and code 8 (F−1) wrap modulo 256 and write only Z.
- R5: Operation code 9 rotates left through carry: the result is {F[6:0], Cin} and the new C is F[7]. Operation code 10 rotates right: the result is {Cin, F[7:1]} and the new C is F[0]. Both write only C.
- R6: Operation code 11 swaps the nibbles of F and operation code 12 passes W. Neither writes any flag.
- R7: The flag vectors place C at bit 0, DC at bit 1 and Z at bit 2. `out_flag_we` has a 1 for each flag the operation wrote. Every flag not written equals the value `in_flags` had when the operation was accepted.
- R8: The reserved operation codes 13, 14 and 15 return F unchanged and write no flag.
- R9: With `REG_OUT`=1, each accepted operation appears on the output one cycle later, in order. `in_ready` equals (!`out_valid` || `out_ready`). While `out_valid` is high and `out_ready` is low, the output fields do not change.
- R10: While reset is active and right after it, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation and operands are present |
| in_ready | output | 1 | Unit can accept an operation |
| in_op | input | 4 | Operation code |
| in_w | input | 8 | Working-register operand W |
| in_f | input | 8 | File or immediate operand F |
| in_flags | input | 3 | Current flags {Z, DC, C} |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 8 | 8-bit result |
| out_flags | output | 3 | Updated flags {Z, DC, C} |
| out_flag_we | output | 3 | Mask of flags written {Z, DC, C} |

## Verification
Some relations are checked by assertions on every cycle:
- For add, the adder's carry matches the 9-bit sum.
- For subtract, the no-borrow bits match unsigned comparisons of the whole operands and of the low nibbles.
- Rotates and swap preserve the bit count, and the rotated-in bit is the old carry.
- Z on the output agrees with a zero result whenever Z is written.
- Flags that are not written keep their entry values.
- A stalled output stays stable.

The bench scenarios are the only way to show the rest. They cover the exact values at wrap points, such as 0xFF+1, 0−1 and 0x10−1. They show that every operation code carries the correct flag mask. Under random back-pressure they show that results come out in order, with none lost and none duplicated.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_PASSF = 4'd0,
    OP_ADD   = 4'd1,
    OP_SUB   = 4'd2,
    OP_AND   = 4'd3,
    OP_OR    = 4'd4,
    OP_XOR   = 4'd5,
    OP_COMF  = 4'd6,
    OP_INC   = 4'd7,
    OP_DEC   = 4'd8,
    OP_RLF   = 4'd9,
    OP_RRF   = 4'd10,
    OP_SWAP  = 4'd11,
    OP_MOVW  = 4'd12,
    OP_RSV13 = 4'd13,
    OP_RSV14 = 4'd14,
    OP_RSV15 = 4'd15
  } alu_op_e;

  localparam int FLG_C  = 0;
  localparam int FLG_DC = 1;
  localparam int FLG_Z  = 2;
  localparam int NFLAGS = 3;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chk_en,
  input  alu_op_e       op,
  input  logic [DW-1:0] w,
  input  logic [DW-1:0] f,
  output logic [DW-1:0] res,
  output logic          c,
  output logic          dc
);
  localparam int NIB = DW / 2;

  logic [DW-1:0] addend;
  logic          cin0;
  logic [DW:0]   full_sum;
  logic [NIB:0]  low_sum;

  // One adder serves every arithmetic operation: subtraction adds ~W plus one.
  always_comb begin
    case (op)
      OP_ADD:  begin addend = w;      cin0 = 1'b0; end
      OP_SUB:  begin addend = ~w;     cin0 = 1'b1; end
      OP_INC:  begin addend = '0;     cin0 = 1'b1; end
      OP_DEC:  begin addend = '1;     cin0 = 1'b0; end
      default: begin addend = w;      cin0 = 1'b0; end
    endcase
  end

  assign full_sum = {1'b0, f} + {1'b0, addend} + {{DW{1'b0}}, cin0};
  assign low_sum  = {1'b0, f[NIB-1:0]} + {1'b0, addend[NIB-1:0]} + {{NIB{1'b0}}, cin0};

  assign res = full_sum[DW-1:0];
  assign c   = full_sum[DW];
  assign dc  = low_sum[NIB];

  p_add_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && op == OP_ADD) |-> ({c, res} == ({1'b0, f} + {1'b0, w})));

  p_sub_nobrw_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && op == OP_SUB) |-> ((c == (f >= w)) && (res == DW'(f - w))));

  p_sub_dc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && op == OP_SUB) |-> (dc == (f[NIB-1:0] >= w[NIB-1:0])));

  p_dec_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && op == OP_DEC) |-> (DW'(res + 1'b1) == f));

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chk_en,
  input  alu_op_e       op,
  input  logic [DW-1:0] w,
  input  logic [DW-1:0] f,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          cout
);
  localparam int NIB = DW / 2;

  always_comb begin
    cout = cin;
    case (op)
      OP_PASSF: res = f;
      OP_AND:   res = f & w;
      OP_OR:    res = f | w;
      OP_XOR:   res = f ^ w;
      OP_COMF:  res = ~f;
      OP_RLF:   begin res = {f[DW-2:0], cin}; cout = f[DW-1]; end
      OP_RRF:   begin res = {cin, f[DW-1:1]}; cout = f[0];    end
      OP_SWAP:  res = {f[NIB-1:0], f[DW-1:NIB]};
      OP_MOVW:  res = w;
      default:  res = f;
    endcase
  end

  // Rotation through carry moves bits without creating or destroying any.
  p_rot_left_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && op == OP_RLF) |->
      (res[0] == cin) && ($countones({cout, res}) == $countones({cin, f})));

  p_rot_right_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && op == OP_RRF) |->
      (res[DW-1] == cin) && ($countones({cout, res}) == $countones({cin, f})));

  p_swap_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && op == OP_SWAP) |-> ($countones(res) == $countones(f)));

endmodule

// File: rtl/alu8_flagsel.sv
module alu8_flagsel
  import alu8_pkg::*;
(
  input  alu_op_e           op,
  output logic [NFLAGS-1:0] mask
);
  localparam logic [NFLAGS-1:0] M_Z   = 3'b100;
  localparam logic [NFLAGS-1:0] M_C   = 3'b001;
  localparam logic [NFLAGS-1:0] M_ALL = 3'b111;

  always_comb begin
    case (op)
      OP_ADD, OP_SUB:                       mask = M_ALL;
      OP_PASSF, OP_AND, OP_OR, OP_XOR,
      OP_COMF, OP_INC, OP_DEC:              mask = M_Z;
      OP_RLF, OP_RRF:                       mask = M_C;
      default:                              mask = '0;
    endcase
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DW      = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [3:0]    in_op,
  input  logic [DW-1:0] in_w,
  input  logic [DW-1:0] in_f,
  input  logic [2:0]    in_flags,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_result,
  output logic [2:0]    out_flags,
  output logic [2:0]    out_flag_we
);
  alu_op_e           op;
  logic [DW-1:0]     a_res, b_res, res_c;
  logic              a_c, a_dc, b_c;
  logic              is_arith;
  logic [NFLAGS-1:0] mask_c, new_fl, merged_fl;

  assign op = alu_op_e'(in_op);

  alu8_arith #(.DW(DW)) u_arith (
    .clk(clk), .rst_n(rst_n), .chk_en(in_valid), .op(op),
    .w(in_w), .f(in_f), .res(a_res), .c(a_c), .dc(a_dc)
  );

  alu8_bitops #(.DW(DW)) u_bitops (
    .clk(clk), .rst_n(rst_n), .chk_en(in_valid), .op(op),
    .w(in_w), .f(in_f), .cin(in_flags[FLG_C]), .res(b_res), .cout(b_c)
  );

  alu8_flagsel u_flagsel (.op(op), .mask(mask_c));

  always_comb begin
    case (op)
      OP_ADD, OP_SUB, OP_INC, OP_DEC: is_arith = 1'b1;
      default:                        is_arith = 1'b0;
    endcase
  end

  assign res_c = is_arith ? a_res : b_res;

  always_comb begin
    new_fl         = '0;
    new_fl[FLG_C]  = is_arith ? a_c : b_c;
    new_fl[FLG_DC] = a_dc;
    new_fl[FLG_Z]  = (res_c == '0);
  end

  assign merged_fl = (mask_c & new_fl) | (~mask_c & in_flags);

  generate
    if (REG_OUT) begin : g_reg
      logic          vld_q;
      logic [DW-1:0] res_q;
      logic [2:0]    fl_q, we_q;

      assign in_ready = !vld_q || out_ready;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          res_q <= '0;
          fl_q  <= '0;
          we_q  <= '0;
        end else if (in_ready) begin
          vld_q <= in_valid;
          if (in_valid) begin
            res_q <= res_c;
            fl_q  <= merged_fl;
            we_q  <= mask_c;
          end
        end
      end

      assign out_valid   = vld_q;
      assign out_result  = res_q;
      assign out_flags   = fl_q;
      assign out_flag_we = we_q;

      p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
          (out_valid && $stable(out_result) && $stable(out_flags) && $stable(out_flag_we)));

      p_keep_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=>
          ((out_flags & ~out_flag_we) == ($past(in_flags) & ~out_flag_we)));
    end else begin : g_comb
      assign in_ready    = out_ready;
      assign out_valid   = in_valid;
      assign out_result  = res_c;
      assign out_flags   = merged_fl;
      assign out_flag_we = mask_c;

      p_keep_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_flags & ~out_flag_we) == (in_flags & ~out_flag_we)));
    end
  endgenerate

  p_z_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flag_we[FLG_Z]) |-> (out_flags[FLG_Z] == (out_result == '0)));

endmodule

// File: tb/alu8_core_tb_top.sv
`timescale 1ns/1ps
module alu8_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] in_op = '0;
  logic [7:0] in_w = '0;
  logic [7:0] in_f = '0;
  logic [2:0] in_flags = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_result;
  logic [2:0] out_flags;
  logic [2:0] out_flag_we;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  bit  rnd_ready = 1'b0;

  logic [13:0] exp_q[$];
  int          op_q[$];

  always #2.5 clk = ~clk;

  alu8_core dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_w(in_w), .in_f(in_f), .in_flags(in_flags),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_flags(out_flags), .out_flag_we(out_flag_we)
  );

  // Expected {mask, flags, result} from the requirement text.
  function automatic logic [13:0] model(int op, int w, int f, logic [2:0] fl);
    int r = f; int m = 0; int c = 0; int dc = 0; int z;
    logic [2:0] nf, mk;
    case (op)
      0:  begin r = f; m = 4; end
      1:  begin r = (f + w) & 255; c = (f + w) > 255 ? 1 : 0;
                dc = ((f & 15) + (w & 15)) > 15 ? 1 : 0; m = 7; end
      2:  begin r = (f - w) & 255; c = (f >= w) ? 1 : 0;
                dc = ((f & 15) >= (w & 15)) ? 1 : 0; m = 7; end
      3:  begin r = f & w; m = 4; end
      4:  begin r = f | w; m = 4; end
      5:  begin r = f ^ w; m = 4; end
      6:  begin r = 255 - f; m = 4; end
      7:  begin r = (f + 1) & 255; m = 4; end
      8:  begin r = (f + 255) & 255; m = 4; end
      9:  begin r = ((f * 2) & 255) + int'(fl[0]); c = f / 128; m = 1; end
      10: begin r = (f / 2) + 128 * int'(fl[0]); c = f % 2; m = 1; end
      11: begin r = ((f % 16) * 16) + (f / 16); m = 0; end
      12: begin r = w; m = 0; end
      default: begin r = f; m = 0; end
    endcase
    z  = (r == 0) ? 1 : 0;
    nf = {z[0], dc[0], c[0]};
    mk = m[2:0];
    return {mk, (mk & nf) | (~mk & fl), r[7:0]};
  endfunction

  function automatic string req_of(int op);
    case (op)
      1: return "R1";
      2: return "R2";
      0, 3, 4, 5, 6: return "R3";
      7, 8: return "R4";
      9, 10: return "R5";
      11, 12: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(negedge clk) begin
    if (rnd_ready) out_ready = ($urandom_range(0, 3) != 0);
    else           out_ready = 1'b1;
  end

  // Observer: samples between edges.
  logic        stall_prev = 1'b0;
  logic [13:0] held;
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (stall_prev)
        check("R9 stall hold", {18'd0, out_flag_we, out_flags, out_result}, {18'd0, held});
      check("R9 ready rule", {31'd0, in_ready}, {31'd0, (!out_valid || out_ready)});
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check("R9 unexpected output", 32'd1, 32'd0);
        end else begin
          logic [13:0] e;
          int o;
          e = exp_q.pop_front();
          o = op_q.pop_front();
          check($sformatf("%s op%0d result/flags", req_of(o), o),
                {21'd0, out_flags, out_result}, {21'd0, e[10:0]});
          check("R7 flag mask", {29'd0, out_flag_we}, {29'd0, e[13:11]});
        end
      end
      if (in_valid && in_ready) begin
        exp_q.push_back(model(int'(in_op), int'(in_w), int'(in_f), in_flags));
        op_q.push_back(int'(in_op));
      end
      stall_prev = out_valid && !out_ready;
      held = {out_flag_we, out_flags, out_result};
    end
  end

  task automatic send(int op, int w, int f, int fl);
    in_valid = 1'b1;
    in_op    = op[3:0];
    in_w     = w[7:0];
    in_f     = f[7:0];
    in_flags = fl[2:0];
    #1.5;
    while (!in_ready) begin
      @(negedge clk);
      #1.5;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R10: idle during and after reset
    check("R10 out_valid in reset", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R10 out_valid after reset", {31'd0, out_valid}, 32'd0);
    check("R10 in_ready after reset", {31'd0, in_ready}, 32'd1);
    @(negedge clk);

    // Directed corners
    send(1, 8'h01, 8'hFF, 0);   // R1 wrap: 0x00, C=1 DC=1 Z=1
    send(1, 8'h08, 8'h08, 0);   // R1 nibble carry only
    send(2, 8'h05, 8'h05, 0);   // R2 equal: zero, no borrow
    send(2, 8'h01, 8'h00, 7);   // R2 0-1 = FF, C=0 DC=0
    send(2, 8'h01, 8'h10, 0);   // R2 0x10-1 = 0F, C=1 DC=0
    send(3, 8'h0F, 8'hF0, 3);   // R3 AND zero, C/DC kept
    send(6, 8'h00, 8'hFF, 0);   // R3 complement to zero
    send(7, 8'h00, 8'hFF, 3);   // R4 inc wrap
    send(8, 8'h00, 8'h01, 0);   // R4 dec to zero
    send(8, 8'h00, 8'h00, 0);   // R4 dec wrap to FF
    send(9, 8'h00, 8'h80, 1);   // R5 rotate left, C in/out
    send(10, 8'h00, 8'h01, 0);  // R5 rotate right to zero, Z kept
    send(11, 8'h00, 8'hA5, 5);  // R6 swap
    send(12, 8'h3C, 8'h00, 2);  // R6 pass W
    send(13, 8'h11, 8'h00, 4);  // R8 reserved
    send(15, 8'h22, 8'h99, 1);  // R8 reserved

    // Random traffic under back-pressure (R9)
    rnd_ready = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      send(int'($urandom_range(0, 15)), int'($urandom_range(0, 255)),
           int'($urandom_range(0, 255)), int'($urandom_range(0, 7)));
      if ($urandom_range(0, 4) == 0) @(negedge clk);
    end
    rnd_ready = 1'b0;
    repeat (6) @(negedge clk);
    check("R9 all results delivered", exp_q.size(), 32'd0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule